// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every beat of one SDRAM read or write burst. A command decoder strobes it with the starting column and the burst mode in force. From the next clock on it presents one column per cycle, with a valid flag. It also raises a last-beat flag on the final beat of a fixed-length burst, and a bank controller uses that flag to launch auto precharge.

The burst mode consists of a three-bit length code and an ordering bit. Both are captured together with the start column. Bursts of 1, 2, 4 or 8 beats stay inside the block of columns aligned to their length. The beats in that block follow either a wrapping increment or an XOR pattern. A full-page burst steps through the whole column range and wraps, and it keeps going until something ends it. A burst stop ends the current burst at any beat. So does a new READ or WRITE command, which also starts the next burst at once.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is asserted and after its release with no strobe, `valid_o` and `last_o` are low.
- R2: A high `start_i` or `restart_i` at a clock edge makes the next cycle the first beat: `valid_o` high and `col_o` equal to the `col_i` sampled at that edge.
- R3: Length code 0, 1, 2 and 3 gives 1, 2, 4 and 8 beats. The reserved codes 4, 5 and 6 give 1 beat. In the cycle after the final beat `valid_o` is low, unless a new strobe was given.
- R4: With ordering bit 0 (sequential) and length L = 2, 4 or 8, beat b carries the low log2(L) start bits plus b, taken modulo L. The upper column bits equal those of the start column.
- R5: With ordering bit 1 (interleaved) and length L = 2, 4 or 8, beat b carries the low log2(L) start bits XOR b. The upper bits are held.
- R6: Length code 7 (full page) presents start+b modulo 2^COL_W on beat b and wraps from the top column to 0. It runs until it is stopped or restarted, and the ordering bit has no effect.
- R7: `last_o` is high only on the final beat of a fixed-length burst and never during a full-page burst.
- R8: A high `stop_i` at an edge with no strobe makes `valid_o` low in the next cycle. A stop given while idle has no effect.
- R9: A strobe given during a burst ends that burst after its current beat, and the new burst starts in the next cycle. A strobe takes priority over a stop at the same edge.
- R10: Changes to `col_i`, `bl_code_i` or `interleave_i` during a burst do not alter that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | READ/WRITE command accepted, begins a burst |
| restart_i | input | 1 | New READ/WRITE during a burst, restarts |
| stop_i | input | 1 | Burst stop |
| col_i | input | COL_W | Starting column |
| bl_code_i | input | 3 | Burst length code (0..3 fixed, 7 full page) |
| interleave_i | input | 1 | Ordering: 0 sequential, 1 interleaved |
| col_o | output | COL_W | Column of the current beat |
| valid_o | output | 1 | A beat is being presented |
| last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
The hardest situations to reach are the truncations: a strobe or stop on an arbitrary beat, a strobe and a stop at the same edge, and a full-page run that crosses the top column and passes its own start column. The driver therefore places each strobe a chosen number of beats into a burst, and it only queues the beats that should appear. It also scrambles the mode inputs right after every start, which exposes any burst that fails to hold its captured mode. A full-page run of 520 beats and a wrap starting at column 510 cover the range edge.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
   localparam int unsigned CODE_W = 3;
   localparam logic [CODE_W-1:0] BLC_ONE   = 3'd0;
   localparam logic [CODE_W-1:0] BLC_TWO   = 3'd1;
   localparam logic [CODE_W-1:0] BLC_FOUR  = 3'd2;
   localparam logic [CODE_W-1:0] BLC_EIGHT = 3'd3;
   localparam logic [CODE_W-1:0] BLC_PAGE  = 3'd7;
   localparam int unsigned MAX_FIXED_LOG = 3;

   typedef enum logic {
      ORD_SEQ = 1'b0,
      ORD_ILV = 1'b1
   } order_e;
endpackage

// File: rtl/colgen_len_decode.sv
module colgen_len_decode
   import colgen_pkg::*;
#(
   parameter int unsigned COL_W = 9
) (
   input  logic [CODE_W-1:0] code_i,
   output logic [COL_W-1:0]  mask_o,
   output logic              page_o
);
   localparam logic [COL_W-1:0] ALL_ONES = {COL_W{1'b1}};

   always_comb begin
      mask_o = '0;
      page_o = 1'b0;
      unique case (code_i)
         BLC_TWO:   mask_o = COL_W'(1);
         BLC_FOUR:  mask_o = COL_W'(3);
         BLC_EIGHT: mask_o = COL_W'(7);
         BLC_PAGE: begin
            mask_o = ALL_ONES;
            page_o = 1'b1;
         end
         default:   mask_o = '0;
      endcase
   end
endmodule

// File: rtl/colgen_ctrl.sv
module colgen_ctrl
   import colgen_pkg::*;
#(
   parameter int unsigned COL_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             stop_i,
   input  logic [COL_W-1:0] col_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic             page_i,
   input  order_e           order_i,
   output logic             active_o,
   output logic [COL_W-1:0] beat_o,
   output logic [COL_W-1:0] base_o,
   output logic [COL_W-1:0] mask_o,
   output logic             page_o,
   output order_e           order_o,
   output logic             last_o
);
   logic             active_q;
   logic [COL_W-1:0] beat_q;
   logic [COL_W-1:0] base_q;
   logic [COL_W-1:0] mask_q;
   logic             page_q;
   order_e           order_q;
   logic             final_beat;

   assign final_beat = active_q && !page_q && (beat_q == mask_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         beat_q   <= '0;
         base_q   <= '0;
         mask_q   <= '0;
         page_q   <= 1'b0;
         order_q  <= ORD_SEQ;
      end else if (load_i) begin
         active_q <= 1'b1;
         beat_q   <= '0;
         base_q   <= col_i;
         mask_q   <= mask_i;
         page_q   <= page_i;
         order_q  <= order_i;
      end else if (active_q) begin
         if (stop_i || final_beat) begin
            active_q <= 1'b0;
         end else begin
            beat_q <= beat_q + COL_W'(1);
         end
      end
   end

   assign active_o = active_q;
   assign beat_o   = beat_q;
   assign base_o   = base_q;
   assign mask_o   = mask_q;
   assign page_o   = page_q;
   assign order_o  = order_q;
   assign last_o   = final_beat;

   p_load_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (active_o && beat_o == '0));
   p_stop_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (active_o && stop_i && !load_i) |=> !active_o);
   p_last_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (last_o && !load_i) |=> !active_o);
   p_idle_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_o && !load_i) |=> !active_o);
   p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (active_o && !last_o && !stop_i && !load_i) |=>
         (active_o && beat_o == $past(beat_o) + COL_W'(1)));
endmodule

// File: rtl/colgen_addr.sv
module colgen_addr
   import colgen_pkg::*;
#(
   parameter int unsigned COL_W  = 9,
   parameter bit          ILV_EN = 1'b1
) (
   input  logic [COL_W-1:0] base_i,
   input  logic [COL_W-1:0] beat_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic             page_i,
   input  order_e           order_i,
   output logic [COL_W-1:0] col_o
);
   logic [COL_W-1:0] step_sum;
   logic [COL_W-1:0] low_bits;

   assign step_sum = base_i + beat_i;

   generate
      if (ILV_EN) begin : g_ilv
         logic use_xor;
         assign use_xor  = (order_i == ORD_ILV) && !page_i;
         assign low_bits = use_xor ? (base_i ^ beat_i) : step_sum;
      end else begin : g_seq_only
         logic unused_order;
         assign unused_order = (order_i == ORD_ILV) ^ page_i;
         assign low_bits     = step_sum;
      end
   endgenerate

   generate
      for (genvar i = 0; i < COL_W; i++) begin : g_merge
         assign col_o[i] = mask_i[i] ? low_bits[i] : base_i[i];
      end
   endgenerate
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
   import colgen_pkg::*;
#(
   parameter int unsigned COL_W  = 9,
   parameter bit          ILV_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             restart_i,
   input  logic             stop_i,
   input  logic [COL_W-1:0] col_i,
   input  logic [2:0]       bl_code_i,
   input  logic             interleave_i,
   output logic [COL_W-1:0] col_o,
   output logic             valid_o,
   output logic             last_o
);
   generate
      if (COL_W < MAX_FIXED_LOG || COL_W > 16) begin : g_bad_width
         $error("sdram_burst_colgen: COL_W must be within 3..16");
      end
   endgenerate

   logic             load;
   logic [COL_W-1:0] dec_mask;
   logic             dec_page;
   order_e           in_order;
   logic [COL_W-1:0] beat;
   logic [COL_W-1:0] base;
   logic [COL_W-1:0] mask_q;
   logic             page_q;
   order_e           order_q;

   assign load     = start_i | restart_i;
   assign in_order = interleave_i ? ORD_ILV : ORD_SEQ;

   colgen_len_decode #(.COL_W(COL_W)) u_dec (
      .code_i (bl_code_i),
      .mask_o (dec_mask),
      .page_o (dec_page)
   );

   colgen_ctrl #(.COL_W(COL_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load),
      .stop_i   (stop_i),
      .col_i    (col_i),
      .mask_i   (dec_mask),
      .page_i   (dec_page),
      .order_i  (in_order),
      .active_o (valid_o),
      .beat_o   (beat),
      .base_o   (base),
      .mask_o   (mask_q),
      .page_o   (page_q),
      .order_o  (order_q),
      .last_o   (last_o)
   );

   colgen_addr #(.COL_W(COL_W), .ILV_EN(ILV_EN)) u_addr (
      .base_i  (base),
      .beat_i  (beat),
      .mask_i  (mask_q),
      .page_i  (page_q),
      .order_i (order_q),
      .col_o   (col_o)
   );

   p_start_col_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (valid_o && col_o == $past(col_i)));
   p_last_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> valid_o);
   p_page_nolast_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && page_q) |-> !last_o);
   p_upper_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !page_q && $past(valid_o) && !$past(load)) |->
         ((col_o & ~mask_q) == $past(col_o & ~mask_q)));
endmodule

// File: tb/sdram_burst_colgen_tb_top.sv
module sdram_burst_colgen_tb_top;
   localparam int unsigned COLW   = 9;
   localparam time         PERIOD = 10ns;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start_i = 1'b0;
   logic            restart_i = 1'b0;
   logic            stop_i = 1'b0;
   logic [COLW-1:0] col_i = '0;
   logic [2:0]      bl_code_i = 3'd0;
   logic            interleave_i = 1'b0;
   logic [COLW-1:0] col_o;
   logic            valid_o;
   logic            last_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   typedef struct {
      logic [COLW-1:0] col;
      logic            last;
      string           tag;
   } beat_t;

   beat_t expq[$];

   always #(PERIOD/2) clk = ~clk;

   sdram_burst_colgen #(.COL_W(COLW)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .restart_i(restart_i),
      .stop_i(stop_i), .col_i(col_i), .bl_code_i(bl_code_i),
      .interleave_i(interleave_i), .col_o(col_o), .valid_o(valid_o),
      .last_o(last_o)
   );

   function automatic int beats_of(input logic [2:0] code);
      case (code)
         3'd1: return 2;
         3'd2: return 4;
         3'd3: return 8;
         3'd7: return 1 << COLW;
         default: return 1;
      endcase
   endfunction

   function automatic logic [COLW-1:0] exp_col(input logic [COLW-1:0] c,
      input logic [2:0] code, input logic il, input int b);
      int n;
      int low;
      int blk;
      n = beats_of(code);
      if (code == 3'd7) return COLW'((int'(c) + b) % (1 << COLW));
      low = int'(c) % n;
      blk = int'(c) - low;
      if (il) return COLW'(blk + (low ^ b));
      return COLW'(blk + ((low + b) % n));
   endfunction

   // monitor: compares every presented beat with the queue
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (valid_o) begin
            total++;
            if (expq.size() == 0) begin
               bad++;
               $display("FAIL R3/R8 unexpected beat col=%0d last=%0b expected no beat",
                        col_o, last_o);
            end else begin
               beat_t e;
               e = expq.pop_front();
               if (col_o !== e.col || last_o !== e.last) begin
                  bad++;
                  $display("FAIL %s col=%0d last=%0b expected col=%0d last=%0b",
                           e.tag, col_o, last_o, e.col, e.last);
               end
            end
         end else if (last_o !== 1'b0) begin
            total++;
            bad++;
            $display("FAIL R7 last without valid: last=%0b expected 0", last_o);
         end
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   // leaves the bench in the cycle that shows beat k-1
   task automatic burst(input logic [COLW-1:0] c, input logic [2:0] code,
                        input logic il, input int k, input bit use_restart,
                        input bit stop_too, input string tag);
      int n;
      n = beats_of(code);
      for (int b = 0; b < k; b++) begin
         beat_t e;
         e.col  = exp_col(c, code, il, b);
         e.last = (code != 3'd7) && (b == n - 1);
         e.tag  = tag;
         expq.push_back(e);
      end
      col_i        = c;
      bl_code_i    = code;
      interleave_i = il;
      start_i      = !use_restart;
      restart_i    = use_restart;
      stop_i       = stop_too;
      tick();
      start_i   = 1'b0;
      restart_i = 1'b0;
      stop_i    = 1'b0;
      // R10: scramble the mode inputs for the rest of the burst
      col_i        = ~c;
      bl_code_i    = code ^ 3'b101;
      interleave_i = ~il;
      for (int i = 0; i < k - 1; i++) tick();
   endtask

   task automatic stop_now();
      stop_i = 1'b1;
      tick();
      stop_i = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic report();
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      #(PERIOD * 150000);
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired: actual hang expected completion");
      report();
      $finish;
   end

   initial begin
      idle(3);
      // R1: outputs during reset
      total++;
      if (valid_o !== 1'b0 || last_o !== 1'b0) begin
         bad++;
         $display("FAIL R1 reset valid=%0b last=%0b expected 0 0", valid_o, last_o);
      end
      rst_n = 1'b1;
      idle(2);
      total++;
      if (valid_o !== 1'b0 || last_o !== 1'b0) begin
         bad++;
         $display("FAIL R1 after reset valid=%0b last=%0b expected 0 0", valid_o, last_o);
      end

      burst(9'h0A5, 3'd3, 1'b0, 8, 1'b0, 1'b0, "R4 seq BL8");
      idle(2);
      burst(9'h0A5, 3'd3, 1'b1, 8, 1'b0, 1'b0, "R5 ilv BL8");
      idle(2);
      burst(9'h102, 3'd2, 1'b0, 4, 1'b0, 1'b0, "R3 seq BL4");
      idle(1);
      burst(9'h1FF, 3'd1, 1'b1, 2, 1'b0, 1'b0, "R5 ilv BL2");
      idle(1);
      burst(9'h033, 3'd0, 1'b0, 1, 1'b0, 1'b0, "R3 BL1");
      idle(1);
      burst(9'h044, 3'd5, 1'b1, 1, 1'b0, 1'b0, "R3 reserved code");
      idle(2);
      burst(9'h0F6, 3'd2, 1'b1, 4, 1'b0, 1'b0, "R5 ilv BL4");
      idle(2);

      // full page wrap across the top column, then stop
      burst(9'd510, 3'd7, 1'b0, 6, 1'b0, 1'b0, "R6 page wrap");
      stop_now();
      idle(3);

      // full page with ordering bit set, truncated by a restart
      burst(9'd3, 3'd7, 1'b1, 10, 1'b0, 1'b0, "R6 page ilv ignored");
      burst(9'h010, 3'd2, 1'b0, 4, 1'b1, 1'b0, "R9 restart after page");
      idle(2);

      // fixed burst truncated by stop on beat 2
      burst(9'h120, 3'd3, 1'b0, 3, 1'b0, 1'b0, "R8 stop BL8");
      stop_now();
      idle(3);

      // strobe and stop together: strobe wins
      burst(9'h0C4, 3'd3, 1'b1, 2, 1'b0, 1'b0, "R9 before collision");
      burst(9'h0C1, 3'd1, 1'b0, 2, 1'b0, 1'b1, "R9 strobe beats stop");
      idle(2);

      // stop while idle has no effect
      stop_now();
      idle(3);

      // back-to-back bursts on the final beat
      burst(9'h055, 3'd1, 1'b0, 2, 1'b0, 1'b0, "R9 chain first");
      burst(9'h067, 3'd2, 1'b1, 4, 1'b1, 1'b0, "R9 chain second");
      idle(2);

      // long full page, past its own start column, no last flag
      burst(9'd100, 3'd7, 1'b0, 520, 1'b0, 1'b0, "R7 page long");
      stop_now();
      idle(3);

      total++;
      if (expq.size() != 0) begin
         bad++;
         $display("FAIL R3 missing beats: actual pending=%0d expected 0", expq.size());
      end
      done = 1'b1;
      report();
      $finish;
   end
endmodule